// File: doc/BRIEF.md
# Word-Address Next-Instruction Fetch Unit

This block keeps the program counter of a single-cycle processor and works out, on every rising clock edge, the address of the next instruction to fetch. Because every instruction is four bytes long and aligned, the two low address bits are always zero; only the 30-bit word address is held in flops, and the byte address handed to instruction memory is that word address with two zero bits appended.

Three ways of moving forward are supported. By default the word address advances by one. A taken conditional branch, signalled by the branch control and the equality flag both high, adds a sign-extended 16-bit word offset on top of that increment, through one shared adder whose carry-in supplies the +1. A jump replaces the low 26 bits of the word address with a target field and keeps the upper four bits of the current address. The jump path wins over either of the other two. The control inputs are plain level signals sampled at each edge. There is no stream handshake, because the counter moves on every cycle and has no back-pressure.

Top module: `nextpc_fetch_unit`

## Requirements
- R1: The two low bits of `iaddr_o` are always 0. Bits [31:2] carry the stored 30-bit word address.
- R2: When `jump_i` is 0 and the branch is not taken, the word address after a rising edge equals the previous word address plus 1.
- R3: When `branch_i` and `zero_i` are both 1 and `jump_i` is 0, the next word address is the previous one plus 1 plus `imm_i` read as a two's-complement number. Negative values move the address backwards.
- R4: A branch that is not taken (`branch_i` = 1, `zero_i` = 0) advances the word address by exactly 1.
- R5: `zero_i` high while `branch_i` is low has no effect on the address, which advances by 1.
- R6: When `jump_i` is 1, the next word address is the previous word address bits [29:26] (byte address bits [31:28]) followed by `target_i[25:0]`.
- R7: `jump_i` takes priority over a taken branch.
- R8: All word-address arithmetic wraps modulo 2^30. Incrementing 0x3FFFFFFF gives 0, and a negative offset below 0 wraps to the top.
- R9: A synchronous active-high `rst` loads `RESET_ADDR` (default 0, low two bits ignored) at the rising edge. It overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_i | input | 16 | Branch word offset, two's complement |
| target_i | input | 26 | Jump word target field |
| branch_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | Compare result equal (branch condition) |
| jump_i | input | 1 | Current instruction is a jump |
| iaddr_o | output | 32 | Byte address of the instruction to fetch |

## Verification
The reference model is given plain sequential steps, positive and negative offsets including the extremes 0x7FFF and 0x8000, and branches that are not taken. Comparing these separates the carry-in increment from the offset addition and exposes a zero-extension or missing sign bit. The equality flag is also driven without the branch control, which shows that the condition is a true AND. Jumps are issued from addresses whose top four bits are all zero and all one, so that lost upper bits become visible, and a jump is issued with a taken branch to test priority. The reset address is placed near the top of the word space so that sequential steps and a backward branch both cross the 2^30 wrap.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_kind_e;
endpackage

// File: rtl/nextpc_offset_sel.sv
module nextpc_offset_sel #(
  parameter int IMM_W = 16,
  parameter int WA_W  = 30
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             take,
  output logic [WA_W-1:0]  offset
);
  localparam int EXT_W = WA_W - IMM_W;
  logic [WA_W-1:0] sext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign sext = imm[WA_W-1:0];
    end
  endgenerate

  // Either nothing or the offset enters the shared adder
  assign offset = take ? sext : '0;
endmodule

// File: rtl/nextpc_word_adder.sv
module nextpc_word_adder #(
  parameter int W = 30
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  endgenerate

  logic carry_out_unused;
  assign carry_out_unused = carry[W];
endmodule

// File: rtl/nextpc_word_reg.sv
module nextpc_word_reg #(
  parameter int              WA_W       = 30,
  parameter logic [WA_W-1:0] RESET_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WA_W-1:0] nxt,
  output logic [WA_W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= RESET_WORD;
    else     cur <= nxt;
  end
endmodule

// File: rtl/nextpc_fetch_unit.sv
module nextpc_fetch_unit #(
  parameter int                ADDR_W     = 32,
  parameter int                IMM_W      = 16,
  parameter int                TGT_W      = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic              branch_i,
  input  logic              zero_i,
  input  logic              jump_i,
  output logic [ADDR_W-1:0] iaddr_o
);
  import nextpc_pkg::*;

  localparam int                WA_W       = ADDR_W - 2;
  localparam int                HI_W       = WA_W - TGT_W;
  localparam logic [WA_W-1:0]   RESET_WORD = RESET_ADDR[ADDR_W-1:2];

  logic [WA_W-1:0] cur_word;
  logic [WA_W-1:0] offset;
  logic [WA_W-1:0] add_word;
  logic [WA_W-1:0] jmp_word;
  logic [WA_W-1:0] nxt_word;
  logic            take_branch;
  nxt_kind_e       kind;

  assign take_branch = branch_i & zero_i;

  always_comb begin
    if (jump_i)           kind = NXT_JUMP;
    else if (take_branch) kind = NXT_BRANCH;
    else                  kind = NXT_SEQ;
  end

  nextpc_offset_sel #(.IMM_W(IMM_W), .WA_W(WA_W)) u_off (
    .imm    (imm_i),
    .take   (kind == NXT_BRANCH),
    .offset (offset)
  );

  // One adder: carry-in supplies the +1 on both paths
  nextpc_word_adder #(.W(WA_W)) u_add (
    .a   (cur_word),
    .b   (offset),
    .cin (1'b1),
    .sum (add_word)
  );

  generate
    if (HI_W > 0) begin : g_keep_hi
      assign jmp_word = {cur_word[WA_W-1 -: HI_W], target_i};
    end else begin : g_full_tgt
      assign jmp_word = target_i[WA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (kind)
      NXT_JUMP: nxt_word = jmp_word;
      default:  nxt_word = add_word;
    endcase
  end

  nextpc_word_reg #(.WA_W(WA_W), .RESET_WORD(RESET_WORD)) u_pc (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_word),
    .cur (cur_word)
  );

  assign iaddr_o = {cur_word, 2'b00};
endmodule

// File: rtl/nextpc_fetch_chk.sv
module nextpc_fetch_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                IMM_W      = 16,
  parameter int                TGT_W      = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [IMM_W-1:0]  imm_i,
  input logic [TGT_W-1:0]  target_i,
  input logic              branch_i,
  input logic              zero_i,
  input logic              jump_i,
  input logic [ADDR_W-1:0] iaddr_o
);
  localparam int WA_W = ADDR_W - 2;
  localparam int HI_W = WA_W - TGT_W;

  logic [WA_W-1:0] w;
  logic [WA_W-1:0] imm_wide;
  assign w        = iaddr_o[ADDR_W-1:2];
  assign imm_wide = WA_W'($signed(imm_i));

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    iaddr_o[1:0] == 2'b00);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && !branch_i) |=> w == $past(w) + WA_W'(1));

  // R3
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && branch_i && zero_i) |=> w == $past(w) + WA_W'(1) + $past(imm_wide));

  // R4
  branch_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && branch_i && !zero_i) |=> w == $past(w) + WA_W'(1));

  // R6
  jump_hi_chk: assert property (@(posedge clk) disable iff (rst)
    jump_i |=> w[WA_W-1 -: HI_W] == $past(w[WA_W-1 -: HI_W]));

  // R7
  jump_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (jump_i && branch_i && zero_i) |=> w[TGT_W-1:0] == $past(target_i));

  // R9
  reset_load_chk: assert property (@(posedge clk)
    rst |=> iaddr_o == {RESET_ADDR[ADDR_W-1:2], 2'b00});
endmodule

bind nextpc_fetch_unit nextpc_fetch_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W), .RESET_ADDR(RESET_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
  .branch_i(branch_i), .zero_i(zero_i), .jump_i(jump_i), .iaddr_o(iaddr_o)
);

// File: tb/nextpc_fetch_unit_tb_top.sv
module nextpc_fetch_unit_tb_top;
  localparam logic [31:0] RST_A = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic        branch_i = 1'b0;
  logic        zero_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [31:0] iaddr_o;

  int checks = 0;
  int failures = 0;
  logic [29:0] model_w;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nextpc_fetch_unit #(.RESET_ADDR(RST_A)) dut_i (
    .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
    .branch_i(branch_i), .zero_i(zero_i), .jump_i(jump_i), .iaddr_o(iaddr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic b, input logic z, input logic j,
                      input logic [15:0] im, input logic [25:0] tg);
    logic [29:0] e;
    longint off;
    branch_i = b; zero_i = z; jump_i = j; imm_i = im; target_i = tg;
    off = longint'($signed(im));
    if (j)            e = {model_w[29:26], tg};
    else if (b && z)  e = 30'(longint'(model_w) + 1 + off);
    else              e = 30'(longint'(model_w) + 1);
    @(posedge clk);
    @(negedge clk);
    model_w = e;
    check(req, iaddr_o, {model_w, 2'b00});
    check("R1", {30'd0, iaddr_o[1:0]}, 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    branch_i = 1'b1; zero_i = 1'b1; jump_i = 1'b1; target_i = 26'h1234; imm_i = 16'h0040;
    @(posedge clk);
    @(negedge clk);
    model_w = RST_A[31:2];
    check("R9", iaddr_o, {model_w, 2'b00});
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R2 / R8: count up through the top of word space
    step("R2", 0, 0, 0, 16'h0000, 26'h0);
    step("R2", 0, 0, 0, 16'h0000, 26'h0);
    step("R2", 0, 0, 0, 16'h0000, 26'h0);
    step("R8", 0, 0, 0, 16'h0000, 26'h0);
    // R5: zero without branch
    step("R5", 0, 1, 0, 16'h0100, 26'h0);
    // R3: positive, negative, extremes
    step("R3", 1, 1, 0, 16'h0005, 26'h0);
    step("R4", 1, 0, 0, 16'h0005, 26'h0);
    step("R3", 1, 1, 0, 16'hFFFD, 26'h0);
    step("R3", 1, 1, 0, 16'h7FFF, 26'h0);
    step("R3", 1, 1, 0, 16'h8000, 26'h0);
    // R6 with upper bits zero
    step("R6", 0, 0, 1, 16'h0000, 26'h0000000);
    // R8: backward branch below zero
    step("R8", 1, 1, 0, 16'hFFFE, 26'h0);
    // R6: upper four bits all ones kept
    step("R6", 0, 0, 1, 16'h0000, 26'h0000155);
    // R7: jump beats taken branch
    step("R7", 1, 1, 1, 16'h0010, 26'h3ABCDEF);
    step("R4", 1, 0, 0, 16'h7000, 26'h0);
    for (int i = 0; i < 20; i++) step("R2", 0, 0, 0, 16'(i * 37), 26'(i));
    step("R3", 1, 1, 0, 16'h0000, 26'h0);
    do_reset();
    step("R2", 0, 0, 0, 16'h0000, 26'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000ns;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule